// File: doc/BRIEF.md
# Pipelined Lifting Wavelet Line Processor

This block computes a one-level, one-dimensional discrete wavelet transform of an image line or signal segment by the lifting method. Each accepted beat carries one even and one odd sample. The block returns one low-pass and one high-pass coefficient per pair, in the same order as the pairs arrived. A per-line mode selects either the integer 5/3 filter, which is reversible, or the fixed-point 9/7 filter. Both filters run through the same chain of five registered stages. The chain has two predict steps, two update steps and one scaling step. In 5/3 mode the second predict/update pair and the scaling stage add nothing to the data.

A line starts with a pair that carries the start flag. That pair also supplies the line length in pairs and the filter mode. Missing neighbours at the two ends of a line are supplied by mirroring. Within a line the block accepts one pair every clock. After the final pair of a line it refuses input for exactly one cycle, so that the predict stages can drain their held pair. Each register-to-register path contains at most one multiplier.

Top module: `lift_dwt1d`

## Requirements
- R1: `in_ready` is high out of reset. After the final pair of a line is accepted, `in_ready` is low for exactly one cycle. It is high at every other time.
- R2: `out_valid` is low after reset until the first coefficient pair is produced.
- R3: In 5/3 mode the high-pass value for pair n is d[n] = o[n] - floor((e[n] + e[n+1]) / 2). At the last pair of a line, e[n+1] is replaced by e[n].
- R4: In 5/3 mode the low-pass value is s[n] = e[n] + floor((d[n-1] + d[n] + 2) / 4). At the first pair of a line, d[n-1] is replaced by d[n]. In 5/3 mode no scaling is applied.
- R5: In 9/7 mode four lifting steps are applied, each of the form t + floor((C * (a + b) + 2048) / 4096), with the same end mirroring as R3 and R4. The constants C are -6497, -217, 3616 and 1817, applied in the order predict, update, predict, update.
- R6: In 9/7 mode the final low-pass value is multiplied by 5039/4096 and the final high-pass value by 3330/4096. Both products are rounded as in R5.
- R7: Exactly one coefficient pair comes out for each accepted pair, in order. `out_first` marks the first output pair of a line and `out_last` marks the last. When input is offered every cycle, the outputs of a line appear in consecutive cycles.
- R8: `in_sol` marks pair 0 of a line. `in_len` (the length in pairs, at least 4) is taken only with that pair. Each line's mirroring is independent, including when lines follow each other back to back.
- R9: Full-scale 16-bit inputs give exact results on the 24-bit signed outputs, with no wrap-around.
- R10: `in_mode` is taken only with the start pair. Its value on the other pairs of a line has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample pair offered |
| in_ready | output | 1 | Pair accepted when high together with in_valid |
| in_sol | input | 1 | Offered pair is pair 0 of a line |
| in_mode | input | 1 | Filter select with in_sol: 0 = 5/3, 1 = 9/7 |
| in_len | input | LEN_W | Line length in pairs, taken with in_sol |
| in_even | input | SAMPLE_W | Even sample, signed |
| in_odd | input | SAMPLE_W | Odd sample, signed |
| out_valid | output | 1 | Coefficient pair present |
| out_first | output | 1 | First coefficient pair of a line |
| out_last | output | 1 | Last coefficient pair of a line |
| out_low | output | 24 | Low-pass coefficient, signed |
| out_high | output | 24 | High-pass coefficient, signed |

## Verification
A held pair that is lost or stale in a predict stage shows up in two ways. The line ends with a missing or duplicated output pair, or the next line starts with `out_first` on the wrong beat. Either is visible within a few cycles of the line's end. A wrong neighbour register in an update stage corrupts the low-pass value of the next pair in the next output cycle. A wrong mirror choice affects only the first or last coefficient of a line, so every line is compared coefficient by coefficient. Both short 4-pair lines and back-to-back lines are run to exercise the ends.

// File: rtl/dwt_lift_pkg.sv
package dwt_lift_pkg;
    localparam int CORE_W = 24;
    localparam int FRAC   = 12;
    localparam int PROD_W = 48;

    typedef logic signed [CORE_W-1:0] word_t;
    typedef logic signed [PROD_W-1:0] wide_t;

    typedef struct packed {
        logic  m97;
        logic  first;
        logic  last;
        word_t ev;
        word_t od;
    } pair_t;

    localparam wide_t HALF = wide_t'(1) <<< (FRAC - 1);

    // Q12 constants: steps 0..3 are lifting, 4 scales low, 5 scales high
    function automatic logic signed [15:0] coef97(input int step);
        case (step)
            0:       return -16'sd6497;
            1:       return -16'sd217;
            2:       return 16'sd3616;
            3:       return 16'sd1817;
            4:       return 16'sd5039;
            default: return 16'sd3330;
        endcase
    endfunction

    function automatic word_t lift_step(input int step, input logic m97,
                                        input word_t tgt, input word_t a, input word_t b);
        wide_t sum;
        wide_t prod;
        sum  = wide_t'(a) + wide_t'(b);
        prod = sum * wide_t'(coef97(step)) + HALF;
        if (m97)
            return tgt + word_t'(prod >>> FRAC);
        case (step)
            0:       return tgt - word_t'(sum >>> 1);
            1:       return tgt + word_t'((sum + wide_t'(2)) >>> 2);
            default: return tgt;
        endcase
    endfunction

    function automatic word_t scale_q12(input word_t v, input int step);
        wide_t prod;
        prod = wide_t'(v) * wide_t'(coef97(step)) + HALF;
        return word_t'(prod >>> FRAC);
    endfunction
endpackage

// File: rtl/dwt_predict.sv
module dwt_predict
    import dwt_lift_pkg::*;
#(
    parameter int STEP = 0
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  vin,
    input  pair_t tin,
    output logic  vout,
    output pair_t tout
);
    typedef struct packed {
        logic  hv;
        pair_t hold;
        logic  ov;
        pair_t o;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.ov = 1'b0;
        if (vin) begin
            if (st_q.hv) begin
                st_d.o    = st_q.hold;
                st_d.o.od = lift_step(STEP, st_q.hold.m97, st_q.hold.od, st_q.hold.ev, tin.ev);
                st_d.ov   = 1'b1;
            end
            st_d.hold = tin;
            st_d.hv   = 1'b1;
        end else if (st_q.hv && st_q.hold.last) begin
            // right neighbour mirrored onto the pair's own even sample
            st_d.o    = st_q.hold;
            st_d.o.od = lift_step(STEP, st_q.hold.m97, st_q.hold.od, st_q.hold.ev, st_q.hold.ev);
            st_d.ov   = 1'b1;
            st_d.hv   = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vout = st_q.ov;
    assign tout = st_q.o;

    // R7: a new pair never arrives while a line's final pair still waits to drain
    a_r7_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(vin && st_q.hv && st_q.hold.last));
endmodule

// File: rtl/dwt_update.sv
module dwt_update
    import dwt_lift_pkg::*;
#(
    parameter int STEP = 1
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  vin,
    input  pair_t tin,
    output logic  vout,
    output pair_t tout
);
    typedef struct packed {
        word_t prev;
        logic  ov;
        pair_t o;
    } st_t;

    st_t   st_d, st_q;
    word_t left;

    always_comb begin
        st_d    = st_q;
        st_d.ov = vin;
        left    = tin.first ? tin.od : st_q.prev;
        if (vin) begin
            st_d.o    = tin;
            st_d.o.ev = lift_step(STEP, tin.m97, tin.ev, left, tin.od);
            st_d.prev = tin.od;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vout = st_q.ov;
    assign tout = st_q.o;
endmodule

// File: rtl/dwt_scale.sv
module dwt_scale
    import dwt_lift_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  vin,
    input  pair_t tin,
    output logic  vout,
    output logic  first,
    output logic  last,
    output word_t lo,
    output word_t hi
);
    typedef struct packed {
        logic  ov;
        logic  first;
        logic  last;
        word_t lo;
        word_t hi;
    } st_t;

    localparam word_t LIM = word_t'(1) <<< 20;

    st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.ov    = vin;
        if (vin) begin
            st_d.first = tin.first;
            st_d.last  = tin.last;
            st_d.lo    = tin.m97 ? scale_q12(tin.ev, 4) : tin.ev;
            st_d.hi    = tin.m97 ? scale_q12(tin.od, 5) : tin.od;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vout  = st_q.ov;
    assign first = st_q.first;
    assign last  = st_q.last;
    assign lo    = st_q.lo;
    assign hi    = st_q.hi;

    // R9: lifted values keep well inside the core word before scaling
    a_r9_headroom: assert property (@(posedge clk) disable iff (!rst_n)
        vin |-> (tin.ev < LIM && tin.ev > -LIM && tin.od < LIM && tin.od > -LIM));
endmodule

// File: rtl/lift_dwt1d.sv
module lift_dwt1d
    import dwt_lift_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int LEN_W    = 10
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    output logic                       in_ready,
    input  logic                       in_sol,
    input  logic                       in_mode,
    input  logic [LEN_W-1:0]           in_len,
    input  logic signed [SAMPLE_W-1:0] in_even,
    input  logic signed [SAMPLE_W-1:0] in_odd,
    output logic                       out_valid,
    output logic                       out_first,
    output logic                       out_last,
    output logic signed [CORE_W-1:0]   out_low,
    output logic signed [CORE_W-1:0]   out_high
);
    localparam int NPAIR = 2;
    localparam int NLINK = 2 * NPAIR + 1;

    typedef struct packed {
        logic             block;
        logic [LEN_W-1:0] cnt;
        logic [LEN_W-1:0] len;
        logic             m97;
    } ctl_t;

    ctl_t             ctl_d, ctl_q;
    logic [LEN_W-1:0] idx, cur_len;
    logic             cur_m, acc;
    pair_t            tok;
    pair_t            link [NLINK];
    logic             lv   [NLINK];

    assign in_ready = !ctl_q.block;
    assign acc      = in_valid && in_ready;

    always_comb begin
        ctl_d     = ctl_q;
        idx       = in_sol ? '0 : ctl_q.cnt;
        cur_len   = in_sol ? in_len : ctl_q.len;
        cur_m     = in_sol ? in_mode : ctl_q.m97;
        tok.m97   = cur_m;
        tok.first = in_sol;
        tok.last  = (idx == cur_len - 1'b1);
        tok.ev    = word_t'(in_even);
        tok.od    = word_t'(in_odd);
        ctl_d.block = acc && tok.last;
        if (acc) begin
            ctl_d.cnt = idx + 1'b1;
            ctl_d.len = cur_len;
            ctl_d.m97 = cur_m;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign link[0] = tok;
    assign lv[0]   = acc;

    for (genvar g = 0; g < NPAIR; g++) begin : g_lift
        dwt_predict #(.STEP(2 * g)) u_pred (
            .clk(clk), .rst_n(rst_n),
            .vin(lv[2*g]), .tin(link[2*g]),
            .vout(lv[2*g+1]), .tout(link[2*g+1])
        );
        dwt_update #(.STEP(2 * g + 1)) u_upd (
            .clk(clk), .rst_n(rst_n),
            .vin(lv[2*g+1]), .tin(link[2*g+1]),
            .vout(lv[2*g+2]), .tout(link[2*g+2])
        );
    end

    dwt_scale u_scale (
        .clk(clk), .rst_n(rst_n),
        .vin(lv[NLINK-1]), .tin(link[NLINK-1]),
        .vout(out_valid), .first(out_first), .last(out_last),
        .lo(out_low), .hi(out_high)
    );

    // R1: the drain gap after a line lasts a single cycle
    a_r1_gap_one: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |=> in_ready);

    // R8: a line is at least four pairs long
    a_r8_len_min: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && in_sol) |-> (in_len >= LEN_W'(4)));
endmodule

// File: tb/lift_dwt1d_test.sv
`timescale 1ns/1ps
module lift_dwt1d_test;
    localparam int LEN_W = 10;
    localparam int WATCH = 100000;
    localparam int RAMP [4][4] = '{'{0, 1, 0, 0}, '{2, 3, 2, 0}, '{4, 5, 4, 0}, '{6, 7, 6, 1}};

    logic clk = 1'b0, rst_n = 1'b0;
    logic in_valid = 1'b0, in_sol = 1'b0, in_mode = 1'b0;
    logic [LEN_W-1:0] in_len = '0;
    logic signed [15:0] in_even = '0, in_odd = '0;
    logic in_ready, out_valid, out_first, out_last;
    logic signed [23:0] out_low, out_high;

    lift_dwt1d #(.SAMPLE_W(16), .LEN_W(LEN_W)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_sol(in_sol), .in_mode(in_mode), .in_len(in_len),
        .in_even(in_even), .in_odd(in_odd), .out_valid(out_valid),
        .out_first(out_first), .out_last(out_last),
        .out_low(out_low), .out_high(out_high)
    );

    always #10 clk = ~clk;

    int checks = 0, errors = 0, cyc = 0, got_n = 0;
    longint e [64], o [64];
    longint exp_lo [256], exp_hi [256], got_lo [256], got_hi [256];
    bit exp_f [256], exp_l [256], got_f [256], got_l [256];
    int got_t [256];
    int unsigned lcg = 32'h1234_5678;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == WATCH) begin
            errors = errors + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    always @(negedge clk) if (out_valid && got_n < 256) begin
        got_lo[got_n] = out_low;  got_hi[got_n] = out_high;
        got_f[got_n]  = out_first; got_l[got_n] = out_last;
        got_t[got_n]  = cyc;      got_n = got_n + 1;
    end

    task automatic check(bit ok, string req, longint act, longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    function automatic longint rq(longint x);
        return (x + 2048) >>> 12;
    endfunction

    task automatic prep(int L, int pat);
        for (int n = 0; n < L; n++) begin
            case (pat)
                0: begin
                    lcg = lcg * 1103515245 + 12345; e[n] = longint'($signed(lcg[30:15]));
                    lcg = lcg * 1103515245 + 12345; o[n] = longint'($signed(lcg[30:15]));
                end
                1: begin e[n] = (n % 2) ? -32768 : 32767; o[n] = (n % 2) ? 32767 : -32768; end
                2: begin e[n] = -32768; o[n] = -32768; end
                default: begin e[n] = 32767; o[n] = -32768; end
            endcase
        end
    endtask

    // behavioural model of R3..R6 with mirrored ends
    task automatic model(bit m97, int L, int base);
        longint d [64], s [64], d2 [64], s2 [64];
        for (int n = 0; n < L; n++) begin
            int r = (n == L - 1) ? n : n + 1;
            d[n] = m97 ? o[n] + rq(-6497 * (e[n] + e[r])) : o[n] - ((e[n] + e[r]) >>> 1);
        end
        for (int n = 0; n < L; n++) begin
            int l = (n == 0) ? 0 : n - 1;
            s[n] = m97 ? e[n] + rq(-217 * (d[l] + d[n])) : e[n] + ((d[l] + d[n] + 2) >>> 2);
        end
        for (int n = 0; n < L; n++) begin
            int r = (n == L - 1) ? n : n + 1;
            d2[n] = m97 ? d[n] + rq(3616 * (s[n] + s[r])) : d[n];
        end
        for (int n = 0; n < L; n++) begin
            int l = (n == 0) ? 0 : n - 1;
            s2[n] = m97 ? s[n] + rq(1817 * (d2[l] + d2[n])) : s[n];
            exp_lo[base+n] = m97 ? rq(5039 * s2[n]) : s2[n];
            exp_hi[base+n] = m97 ? rq(3330 * d2[n]) : d2[n];
            exp_f[base+n]  = (n == 0);
            exp_l[base+n]  = (n == L - 1);
        end
    endtask

    // noise: garbage mode and length on non-start pairs (R8, R10)
    task automatic send_line(int L, bit m97, bit noise);
        for (int n = 0; n < L; n++) begin
            bit ok = 1'b0;
            in_valid = 1'b1; in_sol = (n == 0);
            in_mode  = (n == 0 || !noise) ? m97 : ~m97;
            in_len   = (n == 0) ? LEN_W'(L) : (noise ? LEN_W'(1) : LEN_W'(L));
            in_even  = 16'(e[n]); in_odd = 16'(o[n]);
            while (!ok) begin ok = in_ready; @(negedge clk); end
            if (n == L - 1) check(!in_ready, "R1 drain gap", in_ready, 0);
        end
        in_valid = 1'b0; in_sol = 1'b0;
    endtask

    task automatic finish_run(int total, string req, bit contiguous);
        for (int k = 0; k < 200 && got_n < total; k++) @(negedge clk);
        repeat (12) @(negedge clk);
        check(got_n == total, "R7 output count", got_n, total);
        for (int i = 0; i < total && i < got_n; i++) begin
            check(got_lo[i] == exp_lo[i], {req, " low"}, got_lo[i], exp_lo[i]);
            check(got_hi[i] == exp_hi[i], {req, " high"}, got_hi[i], exp_hi[i]);
            check(got_f[i] == exp_f[i] && got_l[i] == exp_l[i], "R7 line tags",
                  {got_f[i], got_l[i]}, {exp_f[i], exp_l[i]});
            if (contiguous && i > 0 && !exp_f[i])
                check(got_t[i] == got_t[i-1] + 1, "R7 throughput", got_t[i] - got_t[i-1], 1);
        end
        got_n = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R2 reset valid", out_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready == 1'b1, "R1 reset ready", in_ready, 1);
        check(out_valid == 1'b0, "R2 idle valid", out_valid, 0);

        // table walk: 5/3 ramp, hand values for R3 and R4 (end mirrors included)
        for (int n = 0; n < 4; n++) begin
            e[n] = RAMP[n][0]; o[n] = RAMP[n][1];
            exp_lo[n] = RAMP[n][2]; exp_hi[n] = RAMP[n][3];
            exp_f[n] = (n == 0); exp_l[n] = (n == 3);
        end
        send_line(4, 1'b0, 1'b0);
        finish_run(4, "R3 R4 ramp", 1'b1);

        // R3 R4: random 5/3 line
        prep(13, 0); model(1'b0, 13, 0); send_line(13, 1'b0, 1'b0);
        finish_run(13, "R3 R4 random", 1'b1);

        // R5 R6: random 9/7 lines, shortest and longer
        prep(4, 0); model(1'b1, 4, 0); send_line(4, 1'b1, 1'b0);
        finish_run(4, "R5 R6 short", 1'b1);
        prep(32, 0); model(1'b1, 32, 0); send_line(32, 1'b1, 1'b0);
        finish_run(32, "R5 R6 random", 1'b1);

        // R9: full-scale patterns in both modes
        prep(9, 1); model(1'b1, 9, 0); send_line(9, 1'b1, 1'b0);
        finish_run(9, "R9 alternating 97", 1'b1);
        prep(9, 3); model(1'b1, 9, 0); send_line(9, 1'b1, 1'b0);
        finish_run(9, "R9 step 97", 1'b1);
        prep(6, 2); model(1'b0, 6, 0); send_line(6, 1'b0, 1'b0);
        finish_run(6, "R9 min 53", 1'b1);

        // R10 and R8: mode and length garbage on non-start pairs ignored
        prep(7, 0); model(1'b0, 7, 0); send_line(7, 1'b0, 1'b1);
        finish_run(7, "R10 mode held 53", 1'b1);
        prep(7, 0); model(1'b1, 7, 0); send_line(7, 1'b1, 1'b1);
        finish_run(7, "R10 mode held 97", 1'b1);

        // R8: back-to-back lines with mode switch, boundaries independent
        prep(5, 0); model(1'b1, 5, 0);  send_line(5, 1'b1, 1'b0);
        prep(4, 0); model(1'b0, 4, 5);  send_line(4, 1'b0, 1'b0);
        prep(6, 1); model(1'b1, 6, 9);  send_line(6, 1'b1, 1'b0);
        finish_run(15, "R8 back to back", 1'b1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule